// File: doc/BRIEF.md
# Slow-Memory Read Cache

This block puts a small direct-mapped read cache in front of a slow external memory. The CPU side is a byte-wide request/acknowledge bus. The memory side delivers a whole 16-byte line for each read request, after a long fixed latency. When a read hits, the cache acknowledges after two wait states. When a read misses, the CPU is held, the line is fetched, and the access then completes from the newly filled entry.

The cost of fetching a line is hidden in two ways. After a demand fill, the next sequential line is fetched ahead of time. Software can also post a line address through a prefetch strobe; this queues the line without holding the CPU. Writes go straight through to memory. A write also updates the cached copy when the line is present. Lines are not allocated on a write.

Top module: `slowmem_read_cache`

## Requirements
- R1: A read of byte address A returns bits [8*A[3:0]+7 : 8*A[3:0]] of the 128-bit line fetched for line address A[26:4]. All 16 offsets, including both values of address bit 1, return distinct bytes of that line.
- R2: A read that hits completes with `cpu_ack` high for exactly one cycle. The acknowledge is set at the third consecutive rising edge at which `cpu_req` is sampled high, which gives two wait states.
- R3: A read that misses issues a line request with `mem_rd_line` = A[26:4]. `cpu_ack` stays low until the line has arrived, and the read then completes with the correct byte. With a 34-cycle memory, the access takes more than 35 cycles.
- R4: When the memory port is free, the next request is chosen in this order: a demand miss first, then a software prefetch, then a sequential prefetch. A waiting demand miss is issued at the first edge at which the port is free.
- R5: When a demand fill lands for line L, line L+1 is queued as a sequential prefetch; the line number wraps around at the top. Once that fill has landed, reads of line L+1 hit.
- R6: A one-cycle `pf_we` pulse carrying a line number in `pf_line` queues a prefetch of that line without acknowledging or holding the CPU. Once the fill has landed, reads of that line hit.
- R7: A write is acknowledged one edge after `cpu_req` is sampled while the port is free. `mem_we` is pulsed at that same edge with the address and data of the write. A present line gets the new byte. An absent line is not allocated, so a later read of it misses.
- R8: At most one line request is outstanding. A read of a line whose fill is already in flight waits for that fill and issues no second request.
- R9: A software or sequential prefetch of a line that is already present is dropped without issuing a memory request.
- R10: The cache holds 128 lines, indexed by A[10:4] and tagged with A[26:11]. A fill into an index replaces the line held there.
- R11: Reset leaves `cpu_ack`, `mem_rd_req` and `mem_we` low and invalidates every line. A line that was cached before reset misses afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access request, held until acknowledged |
| cpu_we | input | 1 | 1 for a write, 0 for a read |
| cpu_addr | input | 27 | CPU byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte, valid with `cpu_ack` |
| cpu_ack | output | 1 | One-cycle completion pulse |
| pf_we | input | 1 | Software prefetch strobe |
| pf_line | input | 23 | Line number to prefetch |
| mem_rd_req | output | 1 | One-cycle line read request |
| mem_rd_line | output | 23 | Line number requested |
| mem_rd_valid | input | 1 | Line data valid, one cycle |
| mem_rd_data | input | 128 | Returned line, byte k in bits [8k+7:8k] |
| mem_we | output | 1 | One-cycle byte write to memory |
| mem_waddr | output | 27 | Write byte address |
| mem_wdata | output | 8 | Write byte |

## Verification
A corrupted tag or valid bit shows up at the CPU port as a timing error before it shows up as a data error. A line that should hit instead takes the full fill time, and the port log gains an extra request for it. A line that should miss acknowledges after exactly three edges, carrying a byte from another address. A wrong byte select or a missed write update shows in the first read of the affected offset, which comes back with the wrong byte. A broken arbiter shows in the order of requests on the memory port within one fill time, about 35 cycles.

// File: rtl/rc_pkg.sv
package rc_pkg;
  // Source of the line fill currently occupying the memory port.
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_DEMAND = 2'd1,
    SRC_SOFT   = 2'd2,
    SRC_SEQ    = 2'd3
  } fill_src_e;
endpackage

// File: rtl/rc_tag_store.sv
module rc_tag_store #(
  parameter int IDX_W = 7,
  parameter int TAG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  // lookup port for the CPU side
  input  logic [IDX_W-1:0] a_idx,
  input  logic [TAG_W-1:0] a_tag,
  output logic             a_hit,
  // lookup port for the prefetch candidate
  input  logic [IDX_W-1:0] b_idx,
  input  logic [TAG_W-1:0] b_tag,
  output logic             b_hit,
  // install on fill
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else if (fill_en) valid_q[fill_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_idx] <= fill_tag;
  end

  assign a_hit = valid_q[a_idx] && (tag_q[a_idx] == a_tag);
  assign b_hit = valid_q[b_idx] && (tag_q[b_idx] == b_tag);
endmodule

// File: rtl/rc_line_store.sv
module rc_line_store #(
  parameter int IDX_W = 7,
  parameter int OFF_W = 4
) (
  input  logic                      clk,
  input  logic                      fill_en,
  input  logic [IDX_W-1:0]          fill_idx,
  input  logic [(8<<OFF_W)-1:0]     fill_data,
  input  logic                      bw_en,
  input  logic [IDX_W-1:0]          bw_idx,
  input  logic [OFF_W-1:0]          bw_off,
  input  logic [7:0]                bw_data,
  input  logic [IDX_W-1:0]          rd_idx,
  output logic [(8<<OFF_W)-1:0]     rd_line
);
  localparam int LINES     = 1 << IDX_W;
  localparam int LINE_BITS = 8 << OFF_W;

  logic [LINE_BITS-1:0] mem_q [LINES];

  // Fill and byte update never coincide: writes wait while a fill is open.
  always_ff @(posedge clk) begin
    if (fill_en)
      mem_q[fill_idx] <= fill_data;
    else if (bw_en)
      mem_q[bw_idx][{bw_off, 3'b000} +: 8] <= bw_data;
  end

  assign rd_line = mem_q[rd_idx];
endmodule

// File: rtl/rc_fill_engine.sv
module rc_fill_engine
  import rc_pkg::*;
#(
  parameter int LADDR_W = 23
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dem_want,
  input  logic [LADDR_W-1:0] dem_line,
  input  logic               sw_we,
  input  logic [LADDR_W-1:0] sw_line,
  output logic [LADDR_W-1:0] cand_line,
  input  logic               cand_present,
  output logic               mem_rd_req,
  output logic [LADDR_W-1:0] mem_rd_line,
  input  logic               mem_rd_valid,
  output logic               busy,
  output logic               port_idle,
  output logic               land,
  output logic [LADDR_W-1:0] land_line
);
  logic               busy_q, req_q;
  logic [LADDR_W-1:0] cur_line_q;
  fill_src_e          cur_src_q;
  logic               sw_pend_q, seq_pend_q;
  logic [LADDR_W-1:0] sw_line_q, seq_line_q;

  logic sel_sw, cand_valid, issue_dem, issue_pf, drop_pf;

  assign port_idle  = !busy_q;
  assign busy       = busy_q;
  assign land       = busy_q && mem_rd_valid;
  assign land_line  = cur_line_q;

  // Software prefetch outranks sequential prefetch.
  assign sel_sw     = sw_pend_q;
  assign cand_valid = sw_pend_q || seq_pend_q;
  assign cand_line  = sel_sw ? sw_line_q : seq_line_q;

  assign issue_dem = port_idle && dem_want;
  assign issue_pf  = port_idle && !dem_want && cand_valid && !cand_present;
  assign drop_pf   = port_idle && !dem_want && cand_valid && cand_present;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      req_q      <= 1'b0;
      cur_line_q <= '0;
      cur_src_q  <= SRC_NONE;
    end else begin
      req_q <= 1'b0;
      if (issue_dem) begin
        busy_q     <= 1'b1;
        req_q      <= 1'b1;
        cur_line_q <= dem_line;
        cur_src_q  <= SRC_DEMAND;
      end else if (issue_pf) begin
        busy_q     <= 1'b1;
        req_q      <= 1'b1;
        cur_line_q <= cand_line;
        cur_src_q  <= sel_sw ? SRC_SOFT : SRC_SEQ;
      end else if (land) begin
        busy_q    <= 1'b0;
        cur_src_q <= SRC_NONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_pend_q <= 1'b0;
      sw_line_q <= '0;
    end else if (sw_we) begin
      sw_pend_q <= 1'b1;
      sw_line_q <= sw_line;
    end else if ((issue_pf || drop_pf) && sel_sw) begin
      sw_pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_pend_q <= 1'b0;
      seq_line_q <= '0;
    end else if (land && cur_src_q == SRC_DEMAND) begin
      seq_pend_q <= 1'b1;
      seq_line_q <= cur_line_q + 1'b1;
    end else if ((issue_pf || drop_pf) && !sel_sw) begin
      seq_pend_q <= 1'b0;
    end
  end

  assign mem_rd_req  = req_q;
  assign mem_rd_line = cur_line_q;
endmodule

// File: rtl/slowmem_read_cache.sv
module slowmem_read_cache #(
  parameter int ADDR_W   = 27,
  parameter int OFF_W    = 4,
  parameter int IDX_W    = 7,
  parameter int HIT_WAIT = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cpu_req,
  input  logic                         cpu_we,
  input  logic [ADDR_W-1:0]            cpu_addr,
  input  logic [7:0]                   cpu_wdata,
  output logic [7:0]                   cpu_rdata,
  output logic                         cpu_ack,
  input  logic                         pf_we,
  input  logic [ADDR_W-OFF_W-1:0]      pf_line,
  output logic                         mem_rd_req,
  output logic [ADDR_W-OFF_W-1:0]      mem_rd_line,
  input  logic                         mem_rd_valid,
  input  logic [(8<<OFF_W)-1:0]        mem_rd_data,
  output logic                         mem_we,
  output logic [ADDR_W-1:0]            mem_waddr,
  output logic [7:0]                   mem_wdata
);
  localparam int LADDR_W   = ADDR_W - OFF_W;
  localparam int TAG_W     = LADDR_W - IDX_W;
  localparam int LINE_BITS = 8 << OFF_W;
  localparam int CNT_W     = $clog2(HIT_WAIT + 2);

  function automatic logic [LADDR_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction
  function automatic logic [IDX_W-1:0] idx_of(input logic [LADDR_W-1:0] l);
    return l[IDX_W-1:0];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(input logic [LADDR_W-1:0] l);
    return l[LADDR_W-1:IDX_W];
  endfunction
  function automatic logic [7:0] pick_byte(input logic [LINE_BITS-1:0] l,
                                           input logic [OFF_W-1:0] o);
    return l[{o, 3'b000} +: 8];
  endfunction

  // Named internal events (also observed by the checker).
  logic [LADDR_W-1:0]   cpu_line, cand_line, land_line;
  logic [OFF_W-1:0]     cpu_off;
  logic                 cpu_hit, cand_present;
  logic                 rd_active, wr_active, dem_want, wr_go, hit_step;
  logic                 fill_busy, port_idle, land;
  logic [LINE_BITS-1:0] hit_line;

  logic                 ack_q, mem_we_q;
  logic [7:0]           rdata_q, wdata_q;
  logic [ADDR_W-1:0]    waddr_q;
  logic [CNT_W-1:0]     wait_q;

  assign cpu_line  = line_of(cpu_addr);
  assign cpu_off   = cpu_addr[OFF_W-1:0];
  assign rd_active = cpu_req && !cpu_we && !ack_q;
  assign wr_active = cpu_req && cpu_we && !ack_q;
  assign dem_want  = rd_active && !cpu_hit;
  assign hit_step  = rd_active && cpu_hit;
  assign wr_go     = wr_active && !fill_busy;

  rc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_idx    (idx_of(cpu_line)),
    .a_tag    (tag_of(cpu_line)),
    .a_hit    (cpu_hit),
    .b_idx    (idx_of(cand_line)),
    .b_tag    (tag_of(cand_line)),
    .b_hit    (cand_present),
    .fill_en  (land),
    .fill_idx (idx_of(land_line)),
    .fill_tag (tag_of(land_line))
  );

  rc_line_store #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_lines (
    .clk       (clk),
    .fill_en   (land),
    .fill_idx  (idx_of(land_line)),
    .fill_data (mem_rd_data),
    .bw_en     (wr_go && cpu_hit),
    .bw_idx    (idx_of(cpu_line)),
    .bw_off    (cpu_off),
    .bw_data   (cpu_wdata),
    .rd_idx    (idx_of(cpu_line)),
    .rd_line   (hit_line)
  );

  rc_fill_engine #(.LADDR_W(LADDR_W)) u_fill (
    .clk          (clk),
    .rst_n        (rst_n),
    .dem_want     (dem_want),
    .dem_line     (cpu_line),
    .sw_we        (pf_we),
    .sw_line      (pf_line),
    .cand_line    (cand_line),
    .cand_present (cand_present),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_line  (mem_rd_line),
    .mem_rd_valid (mem_rd_valid),
    .busy         (fill_busy),
    .port_idle    (port_idle),
    .land         (land),
    .land_line    (land_line)
  );

  // CPU side: wait-state counter for hits, write-through for writes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q    <= 1'b0;
      mem_we_q <= 1'b0;
      rdata_q  <= '0;
      wdata_q  <= '0;
      waddr_q  <= '0;
      wait_q   <= '0;
    end else begin
      ack_q    <= 1'b0;
      mem_we_q <= 1'b0;
      if (hit_step) begin
        if (wait_q == CNT_W'(HIT_WAIT)) begin
          ack_q   <= 1'b1;
          rdata_q <= pick_byte(hit_line, cpu_off);
          wait_q  <= '0;
        end else begin
          wait_q <= wait_q + 1'b1;
        end
      end else begin
        wait_q <= '0;
      end
      if (wr_go) begin
        ack_q    <= 1'b1;
        mem_we_q <= 1'b1;
        waddr_q  <= cpu_addr;
        wdata_q  <= cpu_wdata;
      end
    end
  end

  assign cpu_ack   = ack_q;
  assign cpu_rdata = rdata_q;
  assign mem_we    = mem_we_q;
  assign mem_waddr = waddr_q;
  assign mem_wdata = wdata_q;
endmodule

// File: rtl/rc_cache_checker.sv
module rc_cache_checker #(
  parameter int ADDR_W   = 27,
  parameter int OFF_W    = 4,
  parameter int HIT_WAIT = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cpu_req,
  input logic                    cpu_we,
  input logic [ADDR_W-1:0]       cpu_addr,
  input logic                    cpu_ack,
  input logic                    mem_rd_req,
  input logic [ADDR_W-OFF_W-1:0] mem_rd_line,
  input logic                    mem_rd_valid,
  input logic                    mem_we,
  input logic [ADDR_W-1:0]       mem_waddr,
  input logic                    dem_want,
  input logic                    port_idle
);
  logic [1:0] out_cnt;
  logic [7:0] run_cnt;

  // Outstanding line requests as seen on the memory port.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_cnt <= '0;
    else if (mem_rd_req && !(mem_rd_valid && out_cnt != 0)) out_cnt <= out_cnt + 1'b1;
    else if (!mem_rd_req && mem_rd_valid && out_cnt != 0) out_cnt <= out_cnt - 1'b1;
  end

  // Edges at which a request has been held without acknowledge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_cnt <= '0;
    else if (!cpu_req) run_cnt <= '0;
    else if (!cpu_ack && run_cnt != 8'hFF) run_cnt <= run_cnt + 1'b1;
  end

  p_single_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> (out_cnt == 2'd0));

  p_demand_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dem_want && port_idle) |=>
      (mem_rd_req && mem_rd_line == $past(cpu_addr[ADDR_W-1:OFF_W])));

  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack);

  p_hit_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !cpu_we) |-> (run_cnt >= 8'(HIT_WAIT + 1)));

  p_write_through_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && cpu_we) |-> (mem_we && mem_waddr == cpu_addr));
endmodule

bind slowmem_read_cache rc_cache_checker #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .HIT_WAIT(HIT_WAIT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_req      (cpu_req),
  .cpu_we       (cpu_we),
  .cpu_addr     (cpu_addr),
  .cpu_ack      (cpu_ack),
  .mem_rd_req   (mem_rd_req),
  .mem_rd_line  (mem_rd_line),
  .mem_rd_valid (mem_rd_valid),
  .mem_we       (mem_we),
  .mem_waddr    (mem_waddr),
  .dem_want     (dem_want),
  .port_idle    (port_idle)
);

// File: tb/slowmem_read_cache_test.sv
module slowmem_read_cache_test;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_LAT    = 34;
  localparam int SETTLE     = 45;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_req = 1'b0, cpu_we = 1'b0;
  logic [26:0]  cpu_addr = '0;
  logic [7:0]   cpu_wdata = '0;
  logic [7:0]   cpu_rdata;
  logic         cpu_ack;
  logic         pf_we = 1'b0;
  logic [22:0]  pf_line = '0;
  logic         mem_rd_req;
  logic [22:0]  mem_rd_line;
  logic         mem_rd_valid = 1'b0;
  logic [127:0] mem_rd_data = '0;
  logic         mem_we;
  logic [26:0]  mem_waddr;
  logic [7:0]   mem_wdata;

  int n_cmp = 0, n_bad = 0;
  logic [7:0]  wr_mem [int];
  logic [22:0] req_log [$];
  logic [7:0]  exp_q [$];
  string       exp_tag [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  slowmem_read_cache uut (.*);

  function automatic logic [7:0] mb(input logic [26:0] a);
    if (wr_mem.exists(int'(a))) return wr_mem[int'(a)];
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ {5'b0, a[26:24]};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Memory model: fixed latency line reads, byte writes.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_rd_req) begin
        automatic logic [22:0] ln = mem_rd_line;
        req_log.push_back(ln);
        repeat (MEM_LAT-1) @(negedge clk);
        for (int k = 0; k < 16; k++) mem_rd_data[8*k +: 8] = mb({ln, 4'(k)});
        mem_rd_valid = 1'b1;
        @(negedge clk);
        mem_rd_valid = 1'b0;
      end
    end
  end

  always @(negedge clk) if (rst_n && mem_we) wr_mem[int'(mem_waddr)] = mem_wdata;

  // Scoreboard monitor: compare each read completion with the expected byte.
  always @(negedge clk) begin
    if (rst_n && cpu_ack && !cpu_we) begin
      if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected ack", 1, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = exp_tag.pop_front();
        chk(cpu_rdata == e, t, "read data", cpu_rdata, e);
      end
    end
  end

  task automatic cpu_read(input logic [26:0] a, input string tag, output int lat);
    @(negedge clk);
    exp_q.push_back(mb(a));
    exp_tag.push_back(tag);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!cpu_ack);
    cpu_req = 1'b0;
  endtask

  task automatic cpu_write(input logic [26:0] a, input logic [7:0] d);
    int n = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    do begin @(negedge clk); n++; end while (!cpu_ack);
    chk(n == 1, "R7", "write ack edges", n, 1);
    chk(mem_we && mem_waddr == a && mem_wdata == d, "R7", "write-through",
        {mem_we, mem_waddr, mem_wdata}, {1'b1, a, d});
    cpu_req = 1'b0;
  endtask

  task automatic sw_prefetch(input logic [22:0] ln);
    @(negedge clk);
    pf_we = 1'b1; pf_line = ln;
    @(negedge clk);
    pf_we = 1'b0;
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  function automatic int count_line(input logic [22:0] ln, input int from);
    int c = 0;
    for (int i = from; i < req_log.size(); i++) if (req_log[i] == ln) c++;
    return c;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R3", "watchdog expired", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int lat, base;
    bit ack_seen;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(!cpu_ack && !mem_rd_req && !mem_we, "R11", "outputs in reset",
        {cpu_ack, mem_rd_req, mem_we}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3, R1: first read misses
    base = req_log.size();
    cpu_read(27'h105, "R1", lat);
    chk(lat > 35, "R3", "miss latency", lat, 36);
    chk(req_log.size() > base && req_log[base] == 23'h10, "R3", "miss line",
        req_log.size() > base ? req_log[base] : 0, 23'h10);
    settle();
    // R5: next line prefetched after demand fill
    chk(count_line(23'h11, base) == 1, "R5", "sequential prefetch", count_line(23'h11, base), 1);
    base = req_log.size();
    cpu_read(27'h113, "R5", lat);
    chk(lat == 3, "R5", "prefetched line hits", lat, 3);
    chk(req_log.size() == base, "R5", "no extra request", req_log.size() - base, 0);

    // R1, R2: every offset of a cached line
    for (int o = 0; o < 16; o++) begin
      cpu_read(27'h100 + 27'(o), "R1", lat);
      chk(lat == 3, "R2", "hit latency", lat, 3);
    end

    // R7: write hit updates cache
    cpu_write(27'h107, 8'hA5);
    base = req_log.size();
    cpu_read(27'h107, "R7", lat);
    chk(lat == 3 && req_log.size() == base, "R7", "updated line still hits", lat, 3);

    // R7: write miss does not allocate
    cpu_write(27'h5004, 8'h3C);
    settle();
    base = req_log.size();
    cpu_read(27'h5004, "R7", lat);
    chk(lat > 35 && count_line(23'h500, base) == 1, "R7", "no allocate on write", lat, 36);
    settle();

    // R6: software prefetch, no CPU acknowledge
    base = req_log.size();
    ack_seen = 0;
    fork
      sw_prefetch(23'h300);
      repeat (4) begin @(negedge clk); if (cpu_ack) ack_seen = 1; end
    join
    chk(!ack_seen, "R6", "prefetch posts no ack", ack_seen, 0);
    settle();
    chk(count_line(23'h300, base) == 1, "R6", "prefetch issued", count_line(23'h300, base), 1);
    cpu_read(27'h3009, "R6", lat);
    chk(lat == 3, "R6", "prefetched line hits", lat, 3);

    // R9: prefetch of a present line is dropped
    base = req_log.size();
    sw_prefetch(23'h10);
    settle();
    chk(req_log.size() == base, "R9", "present line not fetched", req_log.size() - base, 0);

    // R8: read of a line already in flight waits for it
    base = req_log.size();
    sw_prefetch(23'h400);
    repeat (3) @(negedge clk);
    cpu_read(27'h4003, "R8", lat);
    settle();
    chk(count_line(23'h400, base) == 1, "R8", "single fill for line", count_line(23'h400, base), 1);

    // R4: demand before software before sequential
    base = req_log.size();
    fork
      sw_prefetch(23'h600);
      begin repeat (4) @(negedge clk); cpu_read(27'h7002, "R4", lat); end
      begin repeat (8) @(negedge clk); sw_prefetch(23'h800); end
    join
    settle();
    chk(req_log.size() == base + 4, "R4", "request count", req_log.size() - base, 4);
    if (req_log.size() >= base + 4) begin
      chk(req_log[base]   == 23'h600, "R4", "order 0", req_log[base],   23'h600);
      chk(req_log[base+1] == 23'h700, "R4", "demand next", req_log[base+1], 23'h700);
      chk(req_log[base+2] == 23'h800, "R4", "software next", req_log[base+2], 23'h800);
      chk(req_log[base+3] == 23'h701, "R4", "sequential last", req_log[base+3], 23'h701);
    end

    // R10: same index, other tag evicts
    cpu_read(27'h905, "R10", lat);
    chk(lat > 35, "R10", "conflict miss", lat, 36);
    settle();
    cpu_read(27'h105, "R10", lat);
    chk(lat > 35, "R10", "evicted line misses", lat, 36);
    settle();

    // R11: reset invalidates
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    cpu_read(27'h113, "R11", lat);
    chk(lat > 35, "R11", "miss after reset", lat, 36);
    settle();

    chk(exp_q.size() == 0, "R2", "pending expected reads", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule